// File: doc/BRIEF.md
# Dual-Slot Card Status Change Interrupt Unit

This unit watches the status pins of two removable-card sockets and turns their changes into one interrupt line. Each socket supplies eight pins: two voltage-sense lines, write protect, two card-detect lines, two battery-voltage lines and a ready line. After a synchronizer the pins appear in a shared 32-bit pin register. Slot A owns the upper 16-bit half and slot B the lower half, with identical layouts. Every change is latched into a shared change register that software clears by writing ones. A shared enable register chooses which changes may raise the interrupt.

The ready line has four event kinds. Two are edge events (rising and falling) that are latched like the other pins. Two are level events (ready low, ready high) that are never latched. They hold the interrupt asserted for as long as the level persists and the event is enabled. Software reaches the three registers through a simple write-enable, address and data port, and reads them through a combinational read port. A per-slot presence output reports when a card is fully seated.

Top module: `slot_status_irq`

## Requirements
- R1: The pin register (address 0) shows the synchronized pins two clocks after an input change. Bit positions for slot A: vs1=31, vs2=30, wp=29, cd2=28, cd1=27, bvd2=26, bvd1=25, rdy=24. Slot B uses the same positions shifted down by 16. Bits 23:16 and 7:0 read 0.
- R2: Address 1 is the change register and address 2 is the enable register. Writes to address 0 or 3 have no effect, and address 3 reads 0. Only enable bits 31:20 and 15:4 are writable; the other enable bits read 0.
- R3: Each of the eight pin bits of the change register is set on either edge of its synchronized pin. The bit is set one clock after the edge shows in the pin register, and it stays set until cleared.
- R4: Writing a one to a change bit clears it, and writing a zero leaves it unchanged. If a new event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R5: Change bit 21 (slot A) / 5 (slot B) sets only on a rising synchronized ready edge. Change bit 20 / 4 sets only on a falling one.
- R6: Enable bit 23 / 7 (ready low) and enable bit 22 / 6 (ready high) are level events. They raise the interrupt while the synchronized ready level matches, with nothing latched: change bits 23:22, 7:6 and 19:16, 3:0 always read 0.
- R7: irq_o is active high and registered. It is high one clock after the OR of (change AND enable) or an enabled level event is true, and it drops the same way.
- R8: card_present_o[s] is 1 only when both synchronized card-detect pins of slot s are low.
- R9: Reset clears the change register, the enable register, the synchronizer and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vs1_i | input | 2 | Voltage-sense 1 per slot (index 0 = slot A) |
| vs2_i | input | 2 | Voltage-sense 2 per slot |
| wp_i | input | 2 | Write protect per slot |
| cd2_i | input | 2 | Card detect 2 per slot |
| cd1_i | input | 2 | Card detect 1 per slot |
| bvd2_i | input | 2 | Battery voltage 2 per slot |
| bvd1_i | input | 2 | Battery voltage 1 per slot |
| rdy_i | input | 2 | Ready line per slot |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt, active high |
| card_present_o | output | 2 | Card fully seated per slot |

## Verification
The bench aims at a clear that lands in the same cycle as a new edge on the same bit. A design that lets the clear win loses that event. It also checks that ready edges set only their own direction bit; swapped or shared direction logic would set both. The level events are held for many cycles to show that the interrupt stays up with no latched bit and drops when the ready level flips. A latched variant would leave a stuck bit. Slot B has only one card-detect line low, so a presence decode that uses a single line would report a card.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;

    localparam int unsigned SLOTS         = 2;
    localparam int unsigned HALF_W        = 16;
    localparam int unsigned DATA_W        = SLOTS * HALF_W;
    localparam int unsigned PINS_PER_SLOT = 8;

    // offsets inside one slot half for the ready events
    localparam int unsigned OFS_RDY_LOW  = 7;
    localparam int unsigned OFS_RDY_HIGH = 6;
    localparam int unsigned OFS_RDY_RISE = 5;
    localparam int unsigned OFS_RDY_FALL = 4;

    localparam logic [HALF_W-1:0] HALF_PIN_MASK = 16'hFF00;
    localparam logic [HALF_W-1:0] HALF_CHG_MASK = 16'hFF30;
    localparam logic [HALF_W-1:0] HALF_EN_MASK  = 16'hFFF0;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_PINS = 2'd0,
        SEL_CHG  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic word_t spread_half(input logic [HALF_W-1:0] h);
        return {SLOTS{h}};
    endfunction

endpackage

// File: rtl/slot_pin_sync.sv
module slot_pin_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = din_i;
        for (int unsigned i = 1; i <= STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // last synchronizer stage and one extra stage for edge detection
    assign sync_o = st_q.chain[STAGES-1];
    assign prev_o = st_q.chain[STAGES];

endmodule

// File: rtl/slot_event_decode.sv
module slot_event_decode
    import slot_irq_pkg::*;
(
    input  logic [PINS_PER_SLOT-1:0] sync_i,
    input  logic [PINS_PER_SLOT-1:0] prev_i,
    input  logic                     en_low_i,
    input  logic                     en_high_i,
    output logic [HALF_W-1:0]        set_o,
    output logic                     level_o
);

    // pin vector order: vs1 vs2 wp cd2 cd1 bvd2 bvd1 rdy (rdy at bit 0)
    localparam int unsigned RDY_IDX = 0;

    logic rdy_now, rdy_old;

    always_comb begin
        rdy_now = sync_i[RDY_IDX];
        rdy_old = prev_i[RDY_IDX];
        set_o   = '0;
        set_o[HALF_W-1 -: PINS_PER_SLOT] = sync_i ^ prev_i;
        set_o[OFS_RDY_RISE] = rdy_now & ~rdy_old;
        set_o[OFS_RDY_FALL] = ~rdy_now & rdy_old;
        level_o = (en_low_i & ~rdy_now) | (en_high_i & rdy_now);
    end

endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
    import slot_irq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_en_i,
    input  reg_sel_e sel_i,
    input  word_t    wdata_i,
    input  word_t    set_i,
    input  logic     level_i,
    output word_t    chg_o,
    output word_t    en_o,
    output logic     irq_o
);

    typedef struct packed {
        word_t chg;
        word_t en;
        logic  irq;
    } regs_t;

    regs_t r_d, r_q;
    word_t clr;

    always_comb begin
        r_d = r_q;
        clr = (wr_en_i && sel_i == SEL_CHG) ? wdata_i : '0;
        // a fresh event outranks a clear of the same bit
        r_d.chg = ((r_q.chg & ~clr) | set_i) & spread_half(HALF_CHG_MASK);
        if (wr_en_i && sel_i == SEL_EN) begin
            r_d.en = wdata_i & spread_half(HALF_EN_MASK);
        end
        r_d.irq = (|(r_q.chg & r_q.en)) | level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign chg_o = r_q.chg;
    assign en_o  = r_q.en;
    assign irq_o = r_q.irq;

endmodule

// File: rtl/slot_status_irq.sv
module slot_status_irq
    import slot_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SLOTS-1:0]  vs1_i,
    input  logic [SLOTS-1:0]  vs2_i,
    input  logic [SLOTS-1:0]  wp_i,
    input  logic [SLOTS-1:0]  cd2_i,
    input  logic [SLOTS-1:0]  cd1_i,
    input  logic [SLOTS-1:0]  bvd2_i,
    input  logic [SLOTS-1:0]  bvd1_i,
    input  logic [SLOTS-1:0]  rdy_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [SLOTS-1:0]  card_present_o
);

    localparam int unsigned P      = PINS_PER_SLOT;
    localparam int unsigned FLAT_W = SLOTS * P;

    logic [FLAT_W-1:0] raw_flat, sync_flat, prev_flat;
    logic [SLOTS-1:0]  level_vec, rdy_sync;
    word_t             set_vec, pin_word, chg_vec, en_vec;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(addr_i);

    slot_pin_sync #(
        .WIDTH  (FLAT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (raw_flat),
        .sync_o (sync_flat),
        .prev_o (prev_flat)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // slot 0 sits in the upper half, slot 1 below it
        localparam int unsigned LO = DATA_W - (s + 1) * HALF_W;

        assign raw_flat[s*P +: P] = {vs1_i[s], vs2_i[s], wp_i[s], cd2_i[s],
                                     cd1_i[s], bvd2_i[s], bvd1_i[s], rdy_i[s]};

        slot_event_decode u_dec (
            .sync_i    (sync_flat[s*P +: P]),
            .prev_i    (prev_flat[s*P +: P]),
            .en_low_i  (en_vec[LO + OFS_RDY_LOW]),
            .en_high_i (en_vec[LO + OFS_RDY_HIGH]),
            .set_o     (set_vec[LO +: HALF_W]),
            .level_o   (level_vec[s])
        );

        assign pin_word[LO +: HALF_W] = {sync_flat[s*P +: P], {(HALF_W-P){1'b0}}};
        // cd2 at index 4, cd1 at index 3 of the slot pin vector
        assign card_present_o[s] = ~(sync_flat[s*P + 4] | sync_flat[s*P + 3]);
        assign rdy_sync[s]       = sync_flat[s*P];
    end

    slot_status_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .sel_i   (sel),
        .wdata_i (wdata_i),
        .set_i   (set_vec),
        .level_i (|level_vec),
        .chg_o   (chg_vec),
        .en_o    (en_vec),
        .irq_o   (irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_PINS: rdata_o = pin_word & spread_half(HALF_PIN_MASK);
            SEL_CHG:  rdata_o = chg_vec;
            SEL_EN:   rdata_o = en_vec;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/slot_status_irq_chk.sv
module slot_status_irq_chk
    import slot_irq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       addr_i,
    input word_t            wdata_i,
    input word_t            chg_i,
    input word_t            en_i,
    input word_t            set_i,
    input logic [SLOTS-1:0] rdy_sync_i,
    input logic             irq_i
);

    localparam int unsigned LO_A = DATA_W - HALF_W;

    // R6: level and unused positions never latch
    a_r6_no_latch_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_i & ~spread_half(HALF_CHG_MASK)) == '0);

    // R3: without a write to the change register no bit drops
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == SEL_CHG) |=> (($past(chg_i) & ~chg_i) == '0));

    // R4: written ones clear unless a new event hit the same bit
    a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == SEL_CHG) |=> ((chg_i & $past(wdata_i) & ~$past(set_i)) == '0));

    // R2: enable write lands masked
    a_r2_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == SEL_EN) |=> (en_i == ($past(wdata_i) & spread_half(HALF_EN_MASK))));

    // R7: nothing enabled means no interrupt next cycle
    a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == '0) |=> !irq_i);

    // R6: ready-low level on slot A keeps the line up
    a_r6_low_level_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i[LO_A + OFS_RDY_LOW] && !rdy_sync_i[0]) |=> irq_i);

    // R6: ready-high level on slot B keeps the line up
    a_r6_high_level_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i[OFS_RDY_HIGH] && rdy_sync_i[1]) |=> irq_i);

endmodule

bind slot_status_irq slot_status_irq_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .chg_i      (chg_vec),
    .en_i       (en_vec),
    .set_i      (set_vec),
    .rdy_sync_i (rdy_sync),
    .irq_i      (irq_o)
);

// File: tb/test_slot_status_irq.sv
module test_slot_status_irq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  vs1 = 2'b00, vs2 = 2'b00, wp = 2'b00, cd2 = 2'b11, cd1 = 2'b11;
    logic [1:0]  bvd2 = 2'b00, bvd1 = 2'b00, rdy = 2'b11;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [1:0]  present;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [31:0] p1 = '0, p2 = '0, p3 = '0, m_chg = '0, m_en = '0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_status_irq i_slot_status_irq (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .vs1_i          (vs1),
        .vs2_i          (vs2),
        .wp_i           (wp),
        .cd2_i          (cd2),
        .cd1_i          (cd1),
        .bvd2_i         (bvd2),
        .bvd1_i         (bvd1),
        .rdy_i          (rdy),
        .wr_en_i        (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .irq_o          (irq),
        .card_present_o (present)
    );

    function automatic logic [31:0] pack_pins();
        logic [31:0] w = '0;
        for (int s = 0; s < 2; s++) begin
            int b = 31 - 16 * s;
            w[b]   = vs1[s];  w[b-1] = vs2[s];  w[b-2] = wp[s];   w[b-3] = cd2[s];
            w[b-4] = cd1[s];  w[b-5] = bvd2[s]; w[b-6] = bvd1[s]; w[b-7] = rdy[s];
        end
        return w;
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return p2;
            2'd1:    return m_chg;
            2'd2:    return m_en;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [31:0] set, clr;
        logic        n_irq;
        if (!rst_n) begin
            p1 = '0; p2 = '0; p3 = '0; m_chg = '0; m_en = '0; m_irq = 1'b0;
        end else begin
            set = (p2 ^ p3) & 32'hFF00FF00;
            if (p2[24] && !p3[24]) set[21] = 1'b1;
            if (!p2[24] && p3[24]) set[20] = 1'b1;
            if (p2[8] && !p3[8])   set[5]  = 1'b1;
            if (!p2[8] && p3[8])   set[4]  = 1'b1;
            clr = (wr_en && addr == 2'd1) ? wdata : 32'h0;
            n_irq = (|(m_chg & m_en)) | (m_en[23] & ~p2[24]) | (m_en[22] & p2[24])
                  | (m_en[7] & ~p2[8]) | (m_en[6] & p2[8]);
            m_chg = (m_chg & ~clr) | set;
            if (wr_en && addr == 2'd2) m_en = wdata & 32'hFFF0FFF0;
            m_irq = n_irq;
            p3 = p2; p2 = p1; p1 = pack_pins();
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        case (addr)
            2'd0:    chk("R1 pin read", rdata, m_read(addr));
            2'd1:    chk("R3 change read", rdata, m_read(addr));
            default: chk("R2 reg read", rdata, m_read(addr));
        endcase
        chk("R7 irq", {31'h0, irq}, {31'h0, m_irq});
        chk("R8 present", {30'h0, present},
            {30'h0, ~(p2[12] | p2[11]), ~(p2[28] | p2[27])});
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog R7 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        steps(3);
        rst_n = 1'b1;
        #1;
        // R9: everything clear straight out of reset
        rd(2'd1, "R9 change after reset", 32'h0);
        rd(2'd2, "R9 enable after reset", 32'h0);
        chk("R9 irq after reset", {31'h0, irq}, 32'h0);
        steps(4);
        wr(2'd1, 32'hFFFFFFFF);
        step();
        rd(2'd0, "R1 idle pins", 32'h19001900);
        rd(2'd1, "R3 cleared", 32'h0);

        // insert card in slot A
        cd1[0] = 1'b0; cd2[0] = 1'b0;
        steps(4);
        rd(2'd1, "R3 both cd edges", 32'h18000000);
        chk("R8 slot A seated", {31'h0, present[0]}, 32'h1);

        // slot B half seated
        cd1[1] = 1'b0;
        steps(4);
        chk("R8 slot B one cd low", {31'h0, present[1]}, 32'h0);
        rd(2'd1, "R3 slot B cd1", 32'h18000800);

        wr(2'd2, 32'h10000000);
        step();
        chk("R7 irq from enabled change", {31'h0, irq}, 32'h1);
        wr(2'd1, 32'h0);
        rd(2'd1, "R4 zero write keeps", 32'h18000800);
        wr(2'd1, 32'h10000000);
        rd(2'd1, "R4 one write clears", 32'h08000800);
        step();
        chk("R7 irq drops", {31'h0, irq}, 32'h0);
        wr(2'd1, 32'hFFFFFFFF);

        // ready direction events on slot A
        rdy[0] = 1'b0;
        steps(4);
        rd(2'd1, "R5 falling only", 32'h01100000);
        wr(2'd1, 32'hFFFFFFFF);
        rdy[0] = 1'b1;
        steps(4);
        rd(2'd1, "R5 rising only", 32'h01200000);
        wr(2'd1, 32'hFFFFFFFF);

        // level events
        rdy[0] = 1'b0;
        steps(4);
        wr(2'd1, 32'hFFFFFFFF);
        wr(2'd2, 32'h00800000);
        step();
        chk("R6 low level irq", {31'h0, irq}, 32'h1);
        rd(2'd1, "R6 nothing latched", 32'h0);
        steps(6);
        chk("R6 low level held", {31'h0, irq}, 32'h1);
        rdy[0] = 1'b1;
        steps(3);
        chk("R6 level released", {31'h0, irq}, 32'h0);
        wr(2'd2, 32'h00000040);
        step();
        chk("R6 high level slot B", {31'h0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'hFFFFFFFF);
        step();

        // event and clear in the same cycle
        wp[1] = 1'b1;
        step();
        step();
        wr(2'd1, 32'h00002000);
        rd(2'd1, "R4 event beats clear", 32'h00002000);
        wr(2'd1, 32'h00002000);
        rd(2'd1, "R4 later clear", 32'h0);

        // address map corners
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd0, "R2 pin write ignored", 32'h01003100);
        wr(2'd3, 32'hFFFFFFFF);
        rd(2'd3, "R2 spare reads zero", 32'h0);
        rd(2'd1, "R2 spare write ignored", 32'h0);
        wr(2'd2, 32'hFFFFFFFF);
        rd(2'd2, "R2 enable mask", 32'hFFF0FFF0);
        wr(2'd2, 32'h0);
        steps(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule